// File: doc/BRIEF.md
# Real-Time Clock Timekeeping Core with Test Acceleration

This core keeps calendar time from a nominal 32.768 kHz oscillator clock. A free-running binary prescaler turns the oscillator clock into a one-second strobe. That strobe drives eight BCD registers: seconds, minutes, hours, day of month, month, two-digit year, day of week and week number. In normal operation the strobe ripples carries along that chain. The day-to-month carry uses real month lengths and a leap rule based on the year value.

Two test bits in the control register change how the core counts. The first bit shortens the prescaler 32-fold, so all timekeeping runs 32 times faster. The second bit cuts the carries, so every time/date register steps by one on each strobe and wraps inside its own range. With both bits set, every register steps at the accelerated rate. Only software ends a test session, by writing both bits back to zero. The time contents after a session have no defined meaning and should be rewritten.

A plain parallel register port stands in for the host side. Writes land on the next clock edge. Reads are combinational. The port has no streaming data and no handshake: a host may leave it idle for any length of time with no side effect. Running the oscillator clock faster, up to 128 kHz, simply speeds everything up in proportion, including the accelerated test rate.

Top module: `rtc_core`

## Requirements
- R1: After reset the control register reads 0x00 and the time registers read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00, weekday 0x01, week 0x00.
- R2: A write with `host_we` high lands on the next rising clock edge. The register map is: address 0 control, 2 seconds, 3 minutes, 4 hours, 5 day, 6 month, 7 year, 8 weekday, 9 week. Control keeps only bit 2 (accelerate) and bit 3 (no-carry); its other bits read 0. Address 1 and addresses 10 to 15 read 0x00, and writes to them change nothing.
- R3: With bit 2 clear, a one-second strobe occurs every 32768 clocks. A write to seconds restarts the prescaler, so the next strobe updates the registers exactly 32768 rising edges after the edge that took the write.
- R4: With bit 2 set, the strobe period is 1024 clocks, measured in the same way from a seconds write.
- R5: With bit 3 clear, each strobe increments seconds in BCD. Seconds wrap 59 to 00 with a carry into minutes, minutes wrap 59 to 00 with a carry into hours, and hours wrap 23 to 00 with a carry into the day.
- R6: On a day carry, when the day has reached the month length (31, or 30 for months 04, 06, 09 and 11), the day returns to 01 and the month advances. Month 12 returns to 01 and advances the year, and year 99 wraps to 00.
- R7: February (month 02) has 29 days when the year value is divisible by 4, and 28 days otherwise.
- R8: Each day carry also advances the weekday from 1 to 7. A step from 7 back to 1 advances the week number, which wraps from 53 to 00.
- R9: With bit 3 set, each strobe increments every time/date register by one with no carry. Each register wraps within its own range: seconds and minutes 00–59, hours 00–23, day 01–31, month 01–12, year 00–99, weekday 1–7, week 00–53.
- R10: With bits 2 and 3 both set, the no-carry increments of R9 occur at the 1024-clock strobe rate.
- R11: The core never changes the test bits by itself; they change only through a host write to address 0.
- R12: With no host write, the time registers hold their values on every clock that has no strobe, however long the port stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, nominally 32.768 kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Write strobe for the register port |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Combinational read data for `host_addr` |

## Verification
The main function is tried with preset register images. Each image sits on a boundary: a seconds ones digit at 9, each wrap point in the carry chain, the last day of a 30-day month, February in a leap year and in a non-leap year, New Year's Eve with the weekday at 7 and the week at 53, and mid-range values under the no-carry mode. Running an image in accelerated carry mode and again in no-carry mode shows whether the carry gating follows the control bits. A leap-year pair differing only in the year shows whether the leap rule is applied or ignored. Directed tests measure the exact strobe edge in both prescaler modes, check that writes to unused and control bits change nothing, and leave the port idle to show that the registers stay unchanged.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_FIELDS = 8;

  localparam logic [3:0] ADDR_CTRL  = 4'd0;
  localparam logic [3:0] ADDR_FIRST = 4'd2;
  localparam logic [3:0] ADDR_LAST  = 4'd9;

  // field index = address - ADDR_FIRST
  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_DAY  = 3'd3,
    F_MON  = 3'd4,
    F_YEAR = 3'd5,
    F_WDAY = 3'd6,
    F_WEEK = 3'd7
  } field_e;

  function automatic logic [7:0] field_lo(input int idx);
    case (idx)
      3, 4, 6: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] field_hi(input int idx);
    case (idx)
      0, 1:    return 8'h59;
      2:       return 8'h23;
      3:       return 8'h31;
      4:       return 8'h12;
      5:       return 8'h99;
      6:       return 8'h07;
      default: return 8'h53;
    endcase
  endfunction

  // BCD step with wrap; out-of-range inputs fall back to the low bound
  function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
    if (v >= hi)              return lo;
    else if (v[3:0] >= 4'd9)  return {v[7:4] + 4'd1, 4'd0};
    else                      return {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int DIV_LOG   = 15,
  parameter int ACCEL_LOG = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic accel,
  output logic tick
);
  localparam int FAST_LOG = DIV_LOG - ACCEL_LOG;
  localparam logic [DIV_LOG-1:0] FULL_M1 = '1;
  localparam logic [DIV_LOG-1:0] FAST_M1 = {{ACCEL_LOG{1'b0}}, {FAST_LOG{1'b1}}};

  logic [DIV_LOG-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else          pre_q <= pre_q + 1'b1;
  end

  assign tick = accel ? (&pre_q[FAST_LOG-1:0]) : (&pre_q);

  // strobe spacing checker
  logic [DIV_LOG-1:0] gap_q;
  logic               gap_ok_q;
  logic               accel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q    <= '0;
      gap_ok_q <= 1'b1;
      accel_q  <= 1'b0;
    end else begin
      accel_q <= accel;
      if (clr || tick) gap_q <= '0;
      else             gap_q <= gap_q + 1'b1;
      if (accel != accel_q)  gap_ok_q <= 1'b0;
      else if (clr || tick)  gap_ok_q <= 1'b1;
    end
  end

  // R3 and R4: the strobe period follows the selected mode
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gap_ok_q && (accel == accel_q)) |->
      (gap_q == (accel ? FAST_M1 : FULL_M1)));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                       tick,
  input  logic                       no_carry,
  input  logic [NUM_FIELDS-1:0][7:0] cur_i,
  output logic [NUM_FIELDS-1:0][7:0] nxt_o
);
  logic [NUM_FIELDS-1:0][7:0] step;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_step
    assign step[g] = bcd_step(cur_i[g], field_lo(g), field_hi(g));
  end

  logic [6:0] year_bin;
  logic       leap;
  logic [7:0] mlen;

  always_comb begin
    year_bin = 7'(cur_i[F_YEAR][7:4]) * 7'd10 + 7'(cur_i[F_YEAR][3:0]);
    leap     = (year_bin[1:0] == 2'b00);
    case (cur_i[F_MON])
      8'h02:                      mlen = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: mlen = 8'h30;
      default:                    mlen = 8'h31;
    endcase
  end

  logic sec_wrap, min_wrap, hour_wrap, day_roll;
  assign sec_wrap  = cur_i[F_SEC]  >= 8'h59;
  assign min_wrap  = cur_i[F_MIN]  >= 8'h59;
  assign hour_wrap = cur_i[F_HOUR] >= 8'h23;
  assign day_roll  = sec_wrap && min_wrap && hour_wrap;

  always_comb begin
    nxt_o = cur_i;
    if (tick) begin
      if (no_carry) begin
        nxt_o = step;
      end else begin
        nxt_o[F_SEC] = step[F_SEC];
        if (sec_wrap)             nxt_o[F_MIN]  = step[F_MIN];
        if (sec_wrap && min_wrap) nxt_o[F_HOUR] = step[F_HOUR];
        if (day_roll) begin
          nxt_o[F_WDAY] = step[F_WDAY];
          if (cur_i[F_WDAY] >= 8'h07) nxt_o[F_WEEK] = step[F_WEEK];
          if (cur_i[F_DAY] >= mlen) begin
            nxt_o[F_DAY] = 8'h01;
            nxt_o[F_MON] = step[F_MON];
            if (cur_i[F_MON] >= 8'h12) nxt_o[F_YEAR] = step[F_YEAR];
          end else begin
            nxt_o[F_DAY] = step[F_DAY];
          end
        end
      end
    end
  end

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int DIV_LOG   = 15,
  parameter int ACCEL_LOG = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  logic                       accel_q, nocarry_q;
  logic [NUM_FIELDS-1:0][7:0] tf_q, tf_nxt;
  logic                       tick;
  logic                       addr_field, wr_ctrl, wr_field, wr_sec;
  logic [2:0]                 fidx;

  assign addr_field = (host_addr >= ADDR_FIRST) && (host_addr <= ADDR_LAST);
  assign fidx       = 3'(host_addr - ADDR_FIRST);
  assign wr_ctrl    = host_we && (host_addr == ADDR_CTRL);
  assign wr_field   = host_we && addr_field;
  assign wr_sec     = host_we && (host_addr == ADDR_FIRST);

  rtc_divider #(.DIV_LOG(DIV_LOG), .ACCEL_LOG(ACCEL_LOG)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wr_sec),
    .accel (accel_q),
    .tick  (tick)
  );

  rtc_calendar u_cal (
    .tick     (tick),
    .no_carry (nocarry_q),
    .cur_i    (tf_q),
    .nxt_o    (tf_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accel_q   <= 1'b0;
      nocarry_q <= 1'b0;
      for (int i = 0; i < NUM_FIELDS; i++) tf_q[i] <= field_lo(i);
    end else begin
      if (wr_ctrl) begin
        accel_q   <= host_wdata[2];
        nocarry_q <= host_wdata[3];
      end
      tf_q <= tf_nxt;
      if (wr_field) tf_q[fidx] <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (host_addr == ADDR_CTRL) host_rdata = {4'b0, nocarry_q, accel_q, 2'b00};
    else if (addr_field)        host_rdata = tf_q[fidx];
  end

  // R11: test bits move only on a control write
  a_r11_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable({accel_q, nocarry_q}));

  // R12: an idle port and no strobe keep the time
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !host_we) |=> $stable(tf_q));

  // R9: in no-carry mode minutes step on every strobe
  a_r9_no_carry_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && nocarry_q && !host_we) |=> (tf_q[F_MIN] != $past(tf_q[F_MIN])));

  // R5: minutes hold unless seconds wrap
  a_r5_min_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !nocarry_q && !host_we && (tf_q[F_SEC] < 8'h59)) |=> $stable(tf_q[F_MIN]));

  // R2: a seconds write lands on the next edge
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sec |=> (tf_q[F_SEC] == $past(host_wdata)));

endmodule

// File: tb/tb_rtc_core.sv
`timescale 1ns/1ps
module tb_rtc_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [3:0] host_addr = 4'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;

  always #4 clk = ~clk;

  rtc_core dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // {ctrl, preset sec..week, expected sec..week}
  localparam int NVEC = 12;
  localparam logic [135:0] VEC [NVEC] = '{
    {8'h04, 64'h5959_2331_1299_0753, 64'h0000_0001_0100_0100}, // R6 R8 year end
    {8'h04, 64'h5959_2328_0223_0310, 64'h0000_0001_0323_0410}, // R7 non-leap
    {8'h04, 64'h5959_2328_0224_0310, 64'h0000_0029_0224_0410}, // R7 leap
    {8'h04, 64'h5959_2330_0405_0620, 64'h0000_0001_0505_0720}, // R6 30-day month
    {8'h04, 64'h0959_1215_0650_0207, 64'h1059_1215_0650_0207}, // R5 ones digit
    {8'h04, 64'h5909_2315_0650_0207, 64'h0010_2315_0650_0207}, // R5 minute carry
    {8'h04, 64'h5959_0931_0150_0712, 64'h0000_1031_0150_0712}, // R5 hour carry
    {8'h04, 64'h5959_2331_0150_0712, 64'h0000_0001_0250_0113}, // R6 R8 month carry
    {8'h0C, 64'h5930_1015_0540_0320, 64'h0031_1116_0641_0421}, // R10 no carry
    {8'h0C, 64'h5859_2331_1299_0753, 64'h5900_0001_0100_0100}, // R10 wraps
    {8'h0C, 64'h2919_0909_0909_0609, 64'h3020_1010_1010_0710}, // R10 digits
    {8'h0C, 64'h0000_0029_0223_0100, 64'h0101_0130_0324_0201}  // R10 no month cap
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
    host_addr = a;
    #0.2;
    check(req, host_rdata, exp);
  endtask

  task automatic chk_all(input string req, input logic [63:0] exp);
    for (int f = 0; f < 8; f++) chk_reg(req, 4'(f + 2), exp[63 - 8*f -: 8]);
  endtask

  task automatic load_all(input logic [63:0] pre);
    wr(4'd2, pre[63:56]);
    for (int f = 1; f < 8; f++) wr(4'(f + 2), pre[63 - 8*f -: 8]);
    wr(4'd2, pre[63:56]);
  endtask

  initial begin
    repeat (200000 - 5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_reg("R1 ctrl", 4'd0, 8'h00);
    chk_all("R1 time", 64'h0000_0001_0100_0100);

    // R2 control masking, unused addresses
    wr(4'd0, 8'hFF);
    chk_reg("R2 ctrl mask", 4'd0, 8'h0C);
    wr(4'd0, 8'h00);
    chk_reg("R2 ctrl clear", 4'd0, 8'h00);
    wr(4'd1, 8'hAA);
    wr(4'd12, 8'h55);
    chk_reg("R2 addr1", 4'd1, 8'h00);
    chk_reg("R2 addr12", 4'd12, 8'h00);
    chk_reg("R2 addr15", 4'd15, 8'h00);
    chk_all("R2 no side write", 64'h0000_0001_0100_0100);

    // carry and no-carry vectors (R5 R6 R7 R8 R10)
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] c;
      c = VEC[v][135:128];
      wr(4'd0, c);
      load_all(VEC[v][127:64]);
      repeat (c[2] ? 1024 : 32768) @(posedge clk);
      @(negedge clk);
      chk_all(c[3] ? "R10 no-carry fast" : "carry R5 R6 R7 R8", VEC[v][63:0]);
    end

    // R4 accelerated strobe edge
    wr(4'd0, 8'h04);
    wr(4'd2, 8'h20);
    repeat (1023) @(posedge clk);
    @(negedge clk);
    chk_reg("R4 before strobe", 4'd2, 8'h20);
    @(posedge clk); @(negedge clk);
    chk_reg("R4 at strobe", 4'd2, 8'h21);

    // R9 no-carry at the normal rate, R11 bits persist
    wr(4'd0, 8'h08);
    load_all(64'h5930_1015_0540_0320);
    repeat (32767) @(posedge clk);
    @(negedge clk);
    chk_reg("R9 before strobe", 4'd2, 8'h59);
    @(posedge clk); @(negedge clk);
    chk_all("R9 no-carry", 64'h0031_1116_0641_0421);
    chk_reg("R11 bits kept", 4'd0, 8'h08);
    wr(4'd0, 8'h00);
    chk_reg("R11 host clears", 4'd0, 8'h00);

    // R3 normal strobe edge and free running period
    wr(4'd2, 8'h10);
    repeat (32767) @(posedge clk);
    @(negedge clk);
    chk_reg("R3 before strobe", 4'd2, 8'h10);
    @(posedge clk); @(negedge clk);
    chk_reg("R3 at strobe", 4'd2, 8'h11);
    repeat (32767) @(posedge clk);
    @(negedge clk);
    chk_reg("R3 second period early", 4'd2, 8'h11);
    @(posedge clk); @(negedge clk);
    chk_reg("R3 second period", 4'd2, 8'h12);

    // R12 idle port holds time
    wr(4'd2, 8'h45);
    repeat (20000) @(posedge clk);
    @(negedge clk);
    chk_all("R12 idle hold", 64'h4531_1116_0641_0421);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule